// File: doc/BRIEF.md
# Fixed-Latency Varying Iterator

This unit produces the interpolated value of a per-polygon attribute for one fragment. Each coefficient register holds the attribute's value at each of the polygon's vertices. A request names the register to use, the register that holds the per-vertex reciprocal depth term W, an interpolation mode, a vertex selector for flat shading, and the fragment's barycentric weights. The unit drives the two register indices to the coefficient register file in the request cycle and takes both read results in that same cycle.

Three modes exist. Linear mode computes a weighted sum of the vertex values. Perspective mode forms the same weighted sum for the varying and for W, then divides the first by the second in a pipelined divider. Flat mode returns one vertex value unchanged. All arithmetic is fixed-point and no memory is accessed. Every request, whatever its mode, leaves the unit after the same number of cycles with a valid flag beside it. A consumer can therefore schedule the result statically, with no fence and no wait handshake. A new request may enter on every clock cycle.

Top module: `varying_iterator`

## Requirements
- R1: In linear mode (`req_mode_i` = 2'b00), the result is the low 32 bits of (v0*b0 + v1*b1 + v2*b2) arithmetically shifted right by 15. Each vi is a signed 32-bit vertex value, with vertex i at bits [32i+31:32i] of the coefficient data. Each bi is an unsigned Q1.15 weight at bits [16i+15:16i] of `req_bary_i`. All-zero weights give 0.
- R2: In perspective mode (2'b01), let A be the R1 sum of the varying register and Wv the R1 sum of the W register, both taken as signed 32-bit. The result is the low 32 bits of (|A|*65536 / |Wv|), truncated toward zero and negated when exactly one of A and Wv is negative.
- R3: In perspective mode, a zero interpolated W yields a result of 0.
- R4: In flat mode (2'b10), the result is the vertex value chosen by `req_flat_sel_i` (0, 1 or 2). Selector value 3 picks vertex 0. The barycentric weights have no effect.
- R5: Mode 2'b11 behaves exactly like linear mode.
- R6: Every result appears on `res_data_o` with `res_valid_o` high exactly 52 cycles (DATA_W + 16 + 4) after the clock edge that samples its request, in every mode.
- R7: A request is accepted on every cycle with `req_valid_i` high, with no stall. Results leave in request order, and adjacent requests of mixed modes do not affect one another.
- R8: Whenever `res_valid_o` is low, `res_data_o` is zero.
- R9: While `rst_ni` is low, `res_valid_o` and `res_data_o` are zero.
- R10: `cf_var_addr_o` and `cf_w_addr_o` present the request's varying and W register indices in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_mode_i | input | 2 | 00 linear, 01 perspective, 10 flat, 11 treated as linear |
| req_flat_sel_i | input | 2 | Vertex chosen in flat mode |
| req_var_idx_i | input | 6 | Coefficient register of the varying |
| req_w_idx_i | input | 6 | Coefficient register holding W |
| req_bary_i | input | 48 | Three unsigned Q1.15 barycentric weights, weight 0 in the low bits |
| cf_var_addr_o | output | 6 | Read index for the varying register |
| cf_w_addr_o | output | 6 | Read index for the W register |
| cf_var_data_i | input | 96 | Varying register contents, three signed 32-bit vertex values |
| cf_w_data_i | input | 96 | W register contents, three signed 32-bit vertex values |
| res_valid_o | output | 1 | Result present |
| res_data_o | output | 32 | Interpolated value |

## Verification
The register indices are due combinationally in the request cycle. The bench checks them one time step after it drives a request. Each result is due 52 clock edges after its request edge. The bench counts clock edges and files the model's expected valid flag and value under the cycle number that is 52 past the cycle in which it drove the request. At every falling edge it compares the outputs with the entry for the current cycle, so an early, late or missing result fails the same way a wrong value does. Idle cycles hold an expected entry of zero, which covers the zero-data rule between results.

// File: rtl/iter_pkg.sv
package iter_pkg;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'b00,
    MODE_PERSP  = 2'b01,
    MODE_FLAT   = 2'b10,
    MODE_RSVD   = 2'b11
  } iter_mode_e;

  localparam int unsigned DEF_DATA_W     = 32;
  localparam int unsigned DEF_BARY_W     = 16;
  localparam int unsigned DEF_BARY_FRAC  = 15;
  localparam int unsigned DEF_PERSP_FRAC = 16;
  localparam int unsigned DEF_NUM_VERT   = 3;
  localparam int unsigned DEF_IDX_W      = 6;

  // input reg, dot stage, divider prep, one stage per quotient bit, output reg
  function automatic int unsigned iter_latency(int unsigned data_w, int unsigned persp_frac);
    return data_w + persp_frac + 4;
  endfunction

endpackage

// File: rtl/iter_dot.sv
module iter_dot #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BARY_W    = 16,
  parameter int unsigned BARY_FRAC = 15,
  parameter int unsigned NUM_VERT  = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_VERT*DATA_W-1:0]   vals_i,
  input  logic [NUM_VERT*BARY_W-1:0]   bary_i,
  output logic [DATA_W-1:0]            lin_o
);

  localparam int unsigned PROD_W = DATA_W + BARY_W + 1;
  localparam int unsigned SUM_W  = PROD_W + $clog2(NUM_VERT) + 1;

  logic signed [PROD_W-1:0] prod [NUM_VERT];
  logic signed [SUM_W-1:0]  sum;

  for (genvar v = 0; v < NUM_VERT; v++) begin : g_prod
    assign prod[v] = $signed(vals_i[v*DATA_W +: DATA_W]) * $signed({1'b0, bary_i[v*BARY_W +: BARY_W]});
  end

  always_comb begin
    sum = '0;
    for (int v = 0; v < NUM_VERT; v++) begin
      sum = sum + SUM_W'(prod[v]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lin_o <= '0;
    else         lin_o <= sum[BARY_FRAC +: DATA_W];
  end

endmodule

// File: rtl/iter_div_stage.sv
module iter_div_stage #(
  parameter int unsigned DW = 32,
  parameter int unsigned QW = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW+QW-1:0] acc_i,
  input  logic [DW-1:0]    den_i,
  input  logic [DW+3:0]    side_i,
  output logic [DW+QW-1:0] acc_o,
  output logic [DW-1:0]    den_o,
  output logic [DW+3:0]    side_o
);

  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;
  logic [DW-1:0] rem;

  // acc = {partial remainder, remaining dividend bits / quotient bits shifted in}
  always_comb begin
    trial = {acc_i[DW+QW-1:QW], acc_i[QW-1]};
    ge    = trial >= {1'b0, den_i};
    diff  = trial - {1'b0, den_i};
    rem   = ge ? diff[DW-1:0] : trial[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      den_o  <= '0;
      side_o <= '0;
    end else begin
      acc_o  <= {rem, acc_i[QW-2:0], ge};
      den_o  <= den_i;
      side_o <= side_i;
    end
  end

endmodule

// File: rtl/iter_div_pipe.sv
module iter_div_pipe #(
  parameter int unsigned DW   = 32,
  parameter int unsigned FRAC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          persp_i,
  input  logic [DW-1:0] pass_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          valid_o,
  output logic [DW-1:0] res_o
);

  localparam int unsigned QW = DW + FRAC;
  localparam int unsigned SW = DW + 4;
  localparam int unsigned S_VLD  = SW - 1;
  localparam int unsigned S_PER  = SW - 2;
  localparam int unsigned S_NEG  = SW - 3;
  localparam int unsigned S_ZERO = SW - 4;

  logic [DW-1:0]    abs_num, abs_den;
  logic [DW+QW-1:0] p_acc_q;
  logic [DW-1:0]    p_den_q;
  logic [SW-1:0]    p_side_q;

  logic [DW+QW-1:0] st_acc  [QW];
  logic [DW-1:0]    st_den  [QW];
  logic [SW-1:0]    st_side [QW];

  always_comb begin
    abs_num = num_i[DW-1] ? (~num_i + 1'b1) : num_i;
    abs_den = den_i[DW-1] ? (~den_i + 1'b1) : den_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_acc_q  <= '0;
      p_den_q  <= '0;
      p_side_q <= '0;
    end else begin
      p_acc_q  <= {{DW{1'b0}}, abs_num, {FRAC{1'b0}}};
      p_den_q  <= abs_den;
      p_side_q <= {valid_i, persp_i, num_i[DW-1] ^ den_i[DW-1], den_i == '0, pass_i};
    end
  end

  for (genvar k = 0; k < QW; k++) begin : g_stage
    if (k == 0) begin : g_first
      iter_div_stage #(.DW(DW), .QW(QW)) u_stg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .acc_i  (p_acc_q),
        .den_i  (p_den_q),
        .side_i (p_side_q),
        .acc_o  (st_acc[k]),
        .den_o  (st_den[k]),
        .side_o (st_side[k])
      );
    end else begin : g_next
      iter_div_stage #(.DW(DW), .QW(QW)) u_stg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .acc_i  (st_acc[k-1]),
        .den_i  (st_den[k-1]),
        .side_i (st_side[k-1]),
        .acc_o  (st_acc[k]),
        .den_o  (st_den[k]),
        .side_o (st_side[k])
      );
    end
  end

  logic [QW-1:0] quo, quo_s;
  logic [SW-1:0] f_side;
  logic [DW-1:0] res_d;

  always_comb begin
    f_side = st_side[QW-1];
    quo    = st_acc[QW-1][QW-1:0];
    quo_s  = f_side[S_NEG] ? (~quo + 1'b1) : quo;
    if (!f_side[S_VLD])      res_d = '0;
    else if (!f_side[S_PER]) res_d = f_side[DW-1:0];
    else if (f_side[S_ZERO]) res_d = '0;
    else                     res_d = quo_s[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= f_side[S_VLD];
      res_o   <= res_d;
    end
  end

endmodule

// File: rtl/varying_iterator.sv
module varying_iterator
  import iter_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned BARY_W     = DEF_BARY_W,
  parameter int unsigned BARY_FRAC  = DEF_BARY_FRAC,
  parameter int unsigned PERSP_FRAC = DEF_PERSP_FRAC,
  parameter int unsigned NUM_VERT   = DEF_NUM_VERT,
  parameter int unsigned IDX_W      = DEF_IDX_W,
  localparam int unsigned SEL_W     = (NUM_VERT > 1) ? $clog2(NUM_VERT) : 1,
  localparam int unsigned CF_W      = NUM_VERT * DATA_W,
  localparam int unsigned BV_W      = NUM_VERT * BARY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic [SEL_W-1:0]  req_flat_sel_i,
  input  logic [IDX_W-1:0]  req_var_idx_i,
  input  logic [IDX_W-1:0]  req_w_idx_i,
  input  logic [BV_W-1:0]   req_bary_i,
  output logic [IDX_W-1:0]  cf_var_addr_o,
  output logic [IDX_W-1:0]  cf_w_addr_o,
  input  logic [CF_W-1:0]   cf_var_data_i,
  input  logic [CF_W-1:0]   cf_w_data_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o
);

  assign cf_var_addr_o = req_var_idx_i;
  assign cf_w_addr_o   = req_w_idx_i;

  // stage 1: capture request and register reads
  logic             s1_vld_q;
  iter_mode_e       s1_mode_q;
  logic [SEL_W-1:0] s1_sel_q;
  logic [BV_W-1:0]  s1_bary_q;
  logic [CF_W-1:0]  s1_var_q, s1_w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_mode_q <= MODE_LINEAR;
      s1_sel_q  <= '0;
      s1_bary_q <= '0;
      s1_var_q  <= '0;
      s1_w_q    <= '0;
    end else begin
      s1_vld_q  <= req_valid_i;
      s1_mode_q <= iter_mode_e'(req_mode_i);
      s1_sel_q  <= req_flat_sel_i;
      s1_bary_q <= req_bary_i;
      s1_var_q  <= cf_var_data_i;
      s1_w_q    <= cf_w_data_i;
    end
  end

  // stage 2: weighted sums and flat pick
  logic [DATA_W-1:0] lin_var, lin_w, flat_d;
  logic              s2_vld_q;
  iter_mode_e        s2_mode_q;
  logic [DATA_W-1:0] s2_flat_q;

  iter_dot #(.DATA_W(DATA_W), .BARY_W(BARY_W), .BARY_FRAC(BARY_FRAC), .NUM_VERT(NUM_VERT)) u_dot_var (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vals_i (s1_var_q),
    .bary_i (s1_bary_q),
    .lin_o  (lin_var)
  );

  iter_dot #(.DATA_W(DATA_W), .BARY_W(BARY_W), .BARY_FRAC(BARY_FRAC), .NUM_VERT(NUM_VERT)) u_dot_w (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vals_i (s1_w_q),
    .bary_i (s1_bary_q),
    .lin_o  (lin_w)
  );

  // out-of-range selector falls back to vertex 0
  always_comb begin
    flat_d = s1_var_q[DATA_W-1:0];
    for (int v = 1; v < NUM_VERT; v++) begin
      if (s1_sel_q == SEL_W'(v)) flat_d = s1_var_q[v*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q  <= 1'b0;
      s2_mode_q <= MODE_LINEAR;
      s2_flat_q <= '0;
    end else begin
      s2_vld_q  <= s1_vld_q;
      s2_mode_q <= s1_mode_q;
      s2_flat_q <= flat_d;
    end
  end

  logic              s2_persp;
  logic [DATA_W-1:0] s2_pass;

  always_comb begin
    s2_persp = (s2_mode_q == MODE_PERSP);
    s2_pass  = (s2_mode_q == MODE_FLAT) ? s2_flat_q : lin_var;
  end

  // remaining stages: divider with non-perspective results riding alongside
  iter_div_pipe #(.DW(DATA_W), .FRAC(PERSP_FRAC)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s2_vld_q),
    .persp_i (s2_persp),
    .pass_i  (s2_pass),
    .num_i   (lin_var),
    .den_i   (lin_w),
    .valid_o (res_valid_o),
    .res_o   (res_data_o)
  );

endmodule

// File: rtl/iter_checker.sv
module iter_checker
  import iter_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned BARY_W     = DEF_BARY_W,
  parameter int unsigned PERSP_FRAC = DEF_PERSP_FRAC,
  parameter int unsigned NUM_VERT   = DEF_NUM_VERT,
  parameter int unsigned SEL_W      = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic [1:0]                 req_mode_i,
  input logic [SEL_W-1:0]           req_flat_sel_i,
  input logic [NUM_VERT*BARY_W-1:0] req_bary_i,
  input logic [NUM_VERT*DATA_W-1:0] cf_var_data_i,
  input logic [NUM_VERT*DATA_W-1:0] cf_w_data_i,
  input logic                       res_valid_o,
  input logic [DATA_W-1:0]          res_data_o
);

  localparam int unsigned LAT = iter_latency(DATA_W, PERSP_FRAC);

  logic [LAT-1:0]    vld_q, flat_q, zlin_q, zper_q;
  logic [DATA_W-1:0] fval_q [LAT];
  logic [DATA_W-1:0] fval_d;
  logic              is_flat, is_persp;

  always_comb begin
    is_flat  = req_mode_i == MODE_FLAT;
    is_persp = req_mode_i == MODE_PERSP;
    fval_d   = cf_var_data_i[DATA_W-1:0];
    for (int v = 1; v < NUM_VERT; v++) begin
      if (req_flat_sel_i == SEL_W'(v)) fval_d = cf_var_data_i[v*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      flat_q <= '0;
      zlin_q <= '0;
      zper_q <= '0;
      for (int i = 0; i < LAT; i++) fval_q[i] <= '0;
    end else begin
      vld_q  <= {vld_q[LAT-2:0], req_valid_i};
      flat_q <= {flat_q[LAT-2:0], req_valid_i && is_flat};
      zlin_q <= {zlin_q[LAT-2:0], req_valid_i && !is_flat && !is_persp && (req_bary_i == '0)};
      zper_q <= {zper_q[LAT-2:0], req_valid_i && is_persp && (cf_w_data_i == '0)};
      fval_q[0] <= fval_d;
      for (int i = 1; i < LAT; i++) fval_q[i] <= fval_q[i-1];
    end
  end

  p_fixed_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == vld_q[LAT-1]);

  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (res_data_o == '0));

  p_flat_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && flat_q[LAT-1]) |-> (res_data_o == fval_q[LAT-1]));

  p_zero_weights_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && zlin_q[LAT-1]) |-> (res_data_o == '0));

  p_zero_w_persp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && zper_q[LAT-1]) |-> (res_data_o == '0));

endmodule

bind varying_iterator iter_checker #(
  .DATA_W     (DATA_W),
  .BARY_W     (BARY_W),
  .PERSP_FRAC (PERSP_FRAC),
  .NUM_VERT   (NUM_VERT),
  .SEL_W      (SEL_W)
) u_iter_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_mode_i     (req_mode_i),
  .req_flat_sel_i (req_flat_sel_i),
  .req_bary_i     (req_bary_i),
  .cf_var_data_i  (cf_var_data_i),
  .cf_w_data_i    (cf_w_data_i),
  .res_valid_o    (res_valid_o),
  .res_data_o     (res_data_o)
);

// File: tb/sim_varying_iterator.sv
`timescale 1ns/1ps
module sim_varying_iterator;

  localparam int LAT   = 52;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [1:0]  req_sel = '0;
  logic [5:0]  req_vi = '0;
  logic [5:0]  req_wi = '0;
  logic [47:0] req_bary = '0;
  logic [5:0]  cf_var_addr, cf_w_addr;
  logic [95:0] cf_var_data, cf_w_data;
  logic        res_valid;
  logic [31:0] res_data;

  logic [95:0] cf_mem [64];
  assign cf_var_data = cf_mem[cf_var_addr];
  assign cf_w_data   = cf_mem[cf_w_addr];

  always #5 clk = ~clk;

  varying_iterator u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_mode_i     (req_mode),
    .req_flat_sel_i (req_sel),
    .req_var_idx_i  (req_vi),
    .req_w_idx_i    (req_wi),
    .req_bary_i     (req_bary),
    .cf_var_addr_o  (cf_var_addr),
    .cf_w_addr_o    (cf_w_addr),
    .cf_var_data_i  (cf_var_data),
    .cf_w_data_i    (cf_w_data),
    .res_valid_o    (res_valid),
    .res_data_o     (res_data)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  bit    done     = 0;
  bit    exp_vld [DEPTH];
  logic [31:0] exp_dat [DEPTH];
  string exp_tag [DEPTH];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] f_lin(logic [95:0] v, logic [47:0] b);
    longint s = 0;
    for (int i = 0; i < 3; i++)
      s += longint'($signed(v[i*32 +: 32])) * longint'({16'd0, b[i*16 +: 16]});
    s = s >>> 15;
    return s[31:0];
  endfunction

  function automatic logic [31:0] f_persp(logic [95:0] a, logic [95:0] w, logic [47:0] b);
    longint la = longint'($signed(f_lin(a, b)));
    longint lw = longint'($signed(f_lin(w, b)));
    longint q;
    if (lw == 0) return 32'd0;
    q = ((la < 0 ? -la : la) * 65536) / (lw < 0 ? -lw : lw);
    if ((la < 0) != (lw < 0)) q = -q;
    return q[31:0];
  endfunction

  function automatic logic [31:0] f_flat(logic [95:0] v, logic [1:0] sel);
    return (sel < 2'd3) ? v[sel*32 +: 32] : v[31:0];
  endfunction

  function automatic logic [31:0] f_expect(logic [1:0] m, logic [1:0] sel, int vi, int wi, logic [47:0] b);
    case (m)
      2'b01:   return f_persp(cf_mem[vi], cf_mem[wi], b);
      2'b10:   return f_flat(cf_mem[vi], sel);
      default: return f_lin(cf_mem[vi], b);
    endcase
  endfunction

  task automatic issue(bit v, logic [1:0] m, logic [1:0] sel, int vi, int wi, logic [47:0] b, string tag);
    int idx;
    @(negedge clk);
    req_valid = v; req_mode = m; req_sel = sel;
    req_vi = 6'(vi); req_wi = 6'(wi); req_bary = b;
    idx = cyc + LAT;
    if (idx < DEPTH) begin
      exp_vld[idx] = v;
      exp_dat[idx] = v ? f_expect(m, sel, vi, wi, b) : 32'd0;
      exp_tag[idx] = v ? tag : "R8";
    end
    #1;
    if (v) begin
      n_checks++;
      if (cf_var_addr !== 6'(vi) || cf_w_addr !== 6'(wi)) begin
        n_fails++;
        $display("FAIL R10: addr var=%0d w=%0d expected var=%0d w=%0d", cf_var_addr, cf_w_addr, vi, wi);
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(0, 2'($urandom), 2'($urandom), $urandom % 64, $urandom % 64, {$urandom, $urandom}, "R8");
  endtask

  // monitor: compare against the entry filed LAT cycles earlier (R6, R7)
  always @(negedge clk) begin
    if (rst_n && !done && cyc < DEPTH) begin
      n_checks++;
      if (res_valid !== exp_vld[cyc] || res_data !== exp_dat[cyc]) begin
        n_fails++;
        $display("FAIL %s R6: cycle %0d valid=%b data=%h expected valid=%b data=%h",
                 exp_tag[cyc], cyc, res_valid, res_data, exp_vld[cyc], exp_dat[cyc]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      exp_vld[i] = 0; exp_dat[i] = '0; exp_tag[i] = "R8";
    end
    for (int i = 0; i < 64; i++) cf_mem[i] = {$urandom, $urandom, $urandom};
    cf_mem[0] = '0;
    cf_mem[1] = {3{32'h0001_0000}};
    cf_mem[2] = {32'h0000_1234, 32'h8000_0000, 32'h7fff_ffff};
    cf_mem[3] = {32'd300, 32'd200, 32'd100};
    cf_mem[4] = {32'hffff_fed4, 32'hffff_ff38, 32'hffff_ff9c};
    cf_mem[5] = {3{32'h0002_0000}};

    // R9: outputs quiet during reset
    repeat (3) begin
      @(negedge clk);
      n_checks++;
      if (res_valid !== 1'b0 || res_data !== 32'd0) begin
        n_fails++;
        $display("FAIL R9: valid=%b data=%h expected valid=0 data=0", res_valid, res_data);
      end
    end
    rst_n = 1'b1;
    idle(2);

    issue(1, 2'b00, 0, 3, 0, {16'h0, 16'h0, 16'h8000}, "R1");
    issue(1, 2'b00, 0, 3, 0, {16'h2aab, 16'h2aab, 16'h2aab}, "R1");
    issue(1, 2'b00, 0, 3, 9, 48'd0, "R1");
    issue(1, 2'b00, 0, 2, 0, {16'h0, 16'h8000, 16'h0}, "R1");
    issue(1, 2'b00, 0, 3, 0, {16'h0, 16'h0, 16'hffff}, "R1");
    issue(1, 2'b01, 0, 3, 1, {16'h0, 16'h0, 16'h8000}, "R2");
    issue(1, 2'b01, 0, 3, 5, {16'h2000, 16'h2000, 16'h4000}, "R2");
    issue(1, 2'b01, 0, 4, 5, {16'h2aab, 16'h2aab, 16'h2aab}, "R2");
    issue(1, 2'b01, 0, 4, 17, {16'h1000, 16'h3000, 16'h4000}, "R2");
    issue(1, 2'b01, 0, 3, 0, {16'h2aab, 16'h2aab, 16'h2aab}, "R3");
    issue(1, 2'b01, 0, 3, 1, 48'd0, "R3");
    issue(1, 2'b10, 0, 3, 0, {$urandom, $urandom}, "R4");
    issue(1, 2'b10, 1, 3, 0, {$urandom, $urandom}, "R4");
    issue(1, 2'b10, 2, 3, 0, 48'd0, "R4");
    issue(1, 2'b10, 3, 3, 0, {$urandom, $urandom}, "R4");
    issue(1, 2'b11, 0, 3, 7, {16'h2aab, 16'h2aab, 16'h2aab}, "R5");
    issue(1, 2'b11, 2, 2, 7, {16'h1111, 16'h2222, 16'h3333}, "R5");
    idle(3);

    // R7: dense mixed stream, random payloads with gaps
    for (int i = 0; i < 1500; i++) begin
      logic [1:0] m = 2'($urandom);
      string t = (m == 2'b01) ? "R7 R2" : (m == 2'b10) ? "R7 R4" : (m == 2'b11) ? "R7 R5" : "R7 R1";
      issue(($urandom % 4) != 0, m, 2'($urandom), $urandom % 64, $urandom % 64, {$urandom, $urandom}, t);
    end
    idle(LAT + 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule